// File: doc/BRIEF.md
# Programmable Register-Controlled Clock Divider

This block divides the system base clock by a programmable ratio between 1 and 16. It does not produce a new clock net. Instead it produces a one-cycle clock-enable tick once per divided period, and a divided phase level that downstream logic can use as a slow clock reference. A single 8-bit control byte holds the ratio and sits on a simple register bus made of a write strobe, write data and read data.

The ratio is a 4-bit field in bits 7:4 of the control byte, and a field value n selects division by n+1. The field clears to zero on reset, so the block starts at the undivided rate. A new field value is held in a shadow register and moves into the active ratio only when the current divided period ends. No period is ever cut short or stretched by a write.

Top module: `clkdiv_top`

## Requirements
- R1: A divide field value n (bits 7:4 of the control byte) makes every divided period exactly n+1 base-clock cycles long, and all 16 values from 0 to 15 are legal and used as written.
- R2: While and after rst_ni is low, the divide field is 0 and rd_data_o reads 0x00, so the block runs at divide-by-1.
- R3: After a write, the cycle after the write strobe shows the written field on rd_data_o[7:4]. Without a write, rd_data_o holds its value.
- R4: rd_data_o[3:0] always reads 0, and the value written to wr_data_i[3:0] has no effect on any output.
- R5: tick_o is high in exactly one base cycle per divided period: the last cycle of that period.
- R6: At divide-by-1, tick_o and phase_o are both high on every base cycle.
- R7: For a period of N cycles, phase_o is high for the first ceil(N/2) cycles of the period and low for the remaining cycles.
- R8: A write does not change the length of the period in which it occurs. The new ratio governs the period that follows.
- R9: If several writes occur within one period, only the last one written is used for the next period.
- R10: A write made in the last cycle of a period (the cycle in which tick_o is high) governs the period that starts on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System base clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control byte write strobe |
| wr_data_i | input | 8 | Control byte write data; bits 7:4 are the divide field |
| rd_data_o | output | 8 | Control byte read data |
| tick_o | output | 1 | One-cycle enable, high in the last cycle of each divided period |
| phase_o | output | 1 | Divided phase level |

## Verification
A corrupted down-counter or active ratio appears at the ports as a tick spacing or a phase high-time that departs from the model, and the error shows within one divided period (at most 16 cycles). A shadow register that loads wrongly appears on rd_data_o in the cycle after the write, and it also appears as a wrong period length one boundary later. A premature adoption of the shadow value shows up as a period of the wrong length in the same period as the write, which is why writes are placed both in the middle of a period and in its final cycle.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  parameter int unsigned RATIO_W   = 4;
  parameter int unsigned FIELD_LSB = 4;
  parameter int unsigned DATA_W    = RATIO_W + FIELD_LSB;

  typedef logic [RATIO_W-1:0] ratio_t;
  typedef logic [DATA_W-1:0]  ctrl_t;
endpackage

// File: rtl/clkdiv_ratio_reg.sv
module clkdiv_ratio_reg #(
  parameter int unsigned RATIO_W   = clkdiv_pkg::RATIO_W,
  parameter int unsigned FIELD_LSB = clkdiv_pkg::FIELD_LSB,
  parameter int unsigned DATA_W    = RATIO_W + FIELD_LSB
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [RATIO_W-1:0] shadow_o,
  output logic [RATIO_W-1:0] next_ratio_o,
  output logic [DATA_W-1:0]  rd_data_o
);
  logic [RATIO_W-1:0] shadow_q;
  logic [RATIO_W-1:0] wr_field;

  assign wr_field = wr_data_i[FIELD_LSB +: RATIO_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      shadow_q <= '0;
    else if (wr_en_i) shadow_q <= wr_field;
  end

  // bypass so a write in a period's last cycle still lands on the next period
  assign next_ratio_o = wr_en_i ? wr_field : shadow_q;
  assign shadow_o     = shadow_q;

  generate
    if (FIELD_LSB > 0) begin : g_pad
      assign rd_data_o = {shadow_q, {FIELD_LSB{1'b0}}};
    end else begin : g_nopad
      assign rd_data_o = shadow_q;
    end
  endgenerate
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int unsigned RATIO_W = clkdiv_pkg::RATIO_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] next_ratio_i,
  output logic [RATIO_W-1:0] active_o,
  output logic [RATIO_W-1:0] count_o,
  output logic               tick_o
);
  logic [RATIO_W-1:0] active_q;
  logic [RATIO_W-1:0] count_q;
  logic               at_end;

  assign at_end = (count_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      count_q  <= '0;
    end else if (at_end) begin
      active_q <= next_ratio_i;
      count_q  <= next_ratio_i;
    end else begin
      count_q  <= count_q - 1'b1;
    end
  end

  assign active_o = active_q;
  assign count_o  = count_q;
  assign tick_o   = at_end;
endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase #(
  parameter int unsigned RATIO_W = clkdiv_pkg::RATIO_W
) (
  input  logic [RATIO_W-1:0] active_i,
  input  logic [RATIO_W-1:0] count_i,
  output logic               phase_o
);
  localparam int unsigned LEN_W = RATIO_W + 1;

  logic [LEN_W-1:0] period_len;
  logic [LEN_W-1:0] low_len;

  // counter runs N-1..0; high while remaining >= floor(N/2)
  assign period_len = {1'b0, active_i} + LEN_W'(1);
  assign low_len    = period_len >> 1;
  assign phase_o    = ({1'b0, count_i} >= low_len);
endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top #(
  parameter int unsigned RATIO_W   = clkdiv_pkg::RATIO_W,
  parameter int unsigned FIELD_LSB = clkdiv_pkg::FIELD_LSB,
  parameter int unsigned DATA_W    = RATIO_W + FIELD_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              tick_o,
  output logic              phase_o
);
  logic [RATIO_W-1:0] shadow_ratio;
  logic [RATIO_W-1:0] next_ratio;
  logic [RATIO_W-1:0] active_ratio;
  logic [RATIO_W-1:0] count_val;

  clkdiv_ratio_reg #(
    .RATIO_W(RATIO_W), .FIELD_LSB(FIELD_LSB), .DATA_W(DATA_W)
  ) u_reg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .shadow_o     (shadow_ratio),
    .next_ratio_o (next_ratio),
    .rd_data_o    (rd_data_o)
  );

  clkdiv_counter #(.RATIO_W(RATIO_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .next_ratio_i (next_ratio),
    .active_o     (active_ratio),
    .count_o      (count_val),
    .tick_o       (tick_o)
  );

  clkdiv_phase #(.RATIO_W(RATIO_W)) u_phase (
    .active_i (active_ratio),
    .count_i  (count_val),
    .phase_o  (phase_o)
  );
endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk #(
  parameter int unsigned RATIO_W   = clkdiv_pkg::RATIO_W,
  parameter int unsigned FIELD_LSB = clkdiv_pkg::FIELD_LSB,
  parameter int unsigned DATA_W    = RATIO_W + FIELD_LSB
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic [DATA_W-1:0]  rd_data_o,
  input logic               tick_o,
  input logic               phase_o,
  input logic [RATIO_W-1:0] active_ratio,
  input logic [RATIO_W-1:0] count_val
);
  p_readback_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[FIELD_LSB +: RATIO_W] == $past(wr_data_i[FIELD_LSB +: RATIO_W]));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o));

  p_reload_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> count_val == active_ratio);

  p_count_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_val <= active_ratio);

  p_single_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (active_ratio == '0) || !tick_o);

  p_div1_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_ratio == '0 |-> tick_o && phase_o);

  p_phase_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> phase_o);

  p_phase_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && active_ratio != '0) |-> !phase_o);

  p_defer_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(active_ratio));
endmodule

bind clkdiv_top clkdiv_chk #(
  .RATIO_W(RATIO_W), .FIELD_LSB(FIELD_LSB), .DATA_W(DATA_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_data_i    (wr_data_i),
  .rd_data_o    (rd_data_o),
  .tick_o       (tick_o),
  .phase_o      (phase_o),
  .active_ratio (active_ratio),
  .count_val    (count_val)
);

// File: tb/clkdiv_top_tb_top.sv
`timescale 1ns/1ps
module clkdiv_top_tb_top;
  typedef struct packed { logic tick; logic phase; } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       tick_o;
  logic       phase_o;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;
  exp_t exp_q[$];
  logic [3:0] pending = 4'd0;
  logic [7:0] exp_rd  = 8'h00;
  string      scen    = "R1";
  bit         wrote;

  always #2 clk_i = ~clk_i;

  clkdiv_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .tick_o(tick_o), .phase_o(phase_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // expected items for one full period of N cycles (R5, R7)
  task automatic push_period(input int n);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.tick  = (k == n - 1);
      e.phase = (k < (n + 1) / 2);
      exp_q.push_back(e);
    end
  endtask

  // one base cycle: monitor compares, then driver applies this cycle's write
  task automatic step(input bit wr, input logic [3:0] val, input bit only_last);
    exp_t e;
    bit   last;
    @(negedge clk_i);
    e = exp_q.pop_front();
    check(tick_o == e.tick, {scen, " R1 R5 R8 tick"}, tick_o, e.tick);
    check(phase_o == e.phase, {scen, " R6 R7 phase"}, phase_o, e.phase);
    check(rd_data_o == exp_rd, {scen, " R3 R4 readback"}, rd_data_o, exp_rd);
    last  = (exp_q.size() == 0);
    wrote = 1'b0;
    if (wr && (!only_last || last)) begin
      wr_en_i   = 1'b1;
      wr_data_i = {val, 4'(($urandom % 15) + 1)}; // low nibble junk for R4
      pending   = val;
      exp_rd    = {val, 4'h0};
      wrote     = 1'b1;
    end else begin
      wr_en_i   = 1'b0;
      wr_data_i = 8'h5A;
    end
    if (last) push_period(int'(pending) + 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'd0, 1'b0);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R2: reset state
    check(rd_data_o == 8'h00, "R2 reset rd_data", rd_data_o, 0);
    check(tick_o == 1'b1, "R2 reset tick", tick_o, 1);
    check(phase_o == 1'b1, "R2 reset phase", phase_o, 1);
    rst_ni = 1'b1;
    push_period(1);

    scen = "R6";
    idle(12);

    // R1 R7: sweep every encoding
    scen = "R1";
    for (int r = 0; r < 16; r++) begin
      step(1'b1, 4'(r), 1'b0);
      idle(2 * (r + 1) + 3);
    end

    // R8: write mid-period, current period keeps its length
    scen = "R8";
    step(1'b1, 4'd10, 1'b0);
    do step(1'b0, 4'd0, 1'b0); while (!(exp_q.size() == 11));
    idle(4);
    step(1'b1, 4'd3, 1'b0);
    idle(30);

    // R9: several writes in one period, last wins
    scen = "R9";
    step(1'b1, 4'd12, 1'b0);
    idle(20);
    step(1'b1, 4'd5, 1'b0);
    step(1'b1, 4'd2, 1'b0);
    step(1'b1, 4'd7, 1'b0);
    idle(40);

    // R10: write in the tick cycle applies to the very next period
    scen = "R10";
    do step(1'b1, 4'd1, 1'b1); while (!wrote);
    idle(12);
    do step(1'b1, 4'd14, 1'b1); while (!wrote);
    idle(40);
    do step(1'b1, 4'd0, 1'b1); while (!wrote);
    idle(10);

    // random mix
    scen = "R8 R9 R10 mix";
    for (int i = 0; i < 1500; i++) step(($urandom % 9) == 0, 4'($urandom), 1'b0);
    step(1'b0, 4'd0, 1'b0);

    done = 1'b1;
    report();
  end
endmodule